// File: doc/BRIEF.md
# Handshaked DMA Byte Port

This block sits between an external DMA controller and the byte-wide holding registers that feed and drain the SCSI engine. It raises a request toward the controller whenever a byte can be moved. It accepts the controller's acknowledge together with a read or write strobe in place of a chip select and address. It steers the byte into the outgoing holding register or out of the incoming one. There are no address inputs: the acknowledge alone selects the data path.

Two pacing styles are supported. In single-byte style, the request line alone meters the transfers. In block style, the wait-state output holds the controller off until the current byte has been handed on. An active-low end-of-process input, given with the final byte, stops further requests. Once that byte completes, it sets an end-of-transfer flag. A misplaced strobe sets an error flag. The interrupt output is the OR of the two flags. Clearing the mode input clears both flags and withdraws the request.

On the engine side, the outgoing register offers its byte with a valid/ready pair. The incoming register takes a byte from the engine with its own valid/ready pair.

Top module: `hsp_dma_port`

## Requirements
- R1: In the cycle after a synchronous reset, drq, tx_valid, rx_ready, eod_flag, err_flag and irq are 0 and rdy is 1.
- R2: drq is 1 only while dma_en is 1. With dir_out=1 it rises when the outgoing register is empty. With dir_out=0 it rises when the incoming register holds a byte.
- R3: A cycle with dack_n low drives drq to 0 at the next clock edge.
- R4: With dma_en=1 and dir_out=1, the first cycle of dack_n and wr_n both low, when the outgoing register is empty, loads hd_i into it. tx_valid=1 and tx_data then hold that byte until a cycle with tx_ready=1 takes it.
- R5: With dma_en=1 and dir_out=0, rx_ready is 1 while the incoming register is empty and no read strobe is active. While dack_n and rd_n are both low, hd_oe=1 and hd_o carries the held byte. The first such cycle empties the register.
- R6: With dma_en=1 and blk_en=1, rdy is 1 when a byte can move (outgoing empty, or incoming full) and 0 otherwise. With blk_en=0 or dma_en=0, rdy is 1.
- R7: If eop_n is low in a strobe cycle that moves a byte, eod_flag and irq go to 1 once that byte completes. For a write, the byte completes when the engine takes it; for a read, it completes in the read cycle itself. From then on, drq and rx_ready stay 0.
- R8: A cycle with dma_en=0 clears eod_flag and err_flag at the next edge, so irq falls.
- R9: Strobes given while dma_en=0 are ignored: no byte is loaded, no flag is set, and hd_oe stays 0.
- R10: A write strobe while the outgoing register is full, or with dir_out=0, sets err_flag and irq, and the held byte is kept. A read strobe while the incoming register is empty, or with dir_out=1, does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | DMA mode enable |
| blk_en | input | 1 | Block-style pacing through rdy |
| dir_out | input | 1 | 1: controller writes toward SCSI; 0: controller reads from SCSI |
| dack_n | input | 1 | DMA acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| eop_n | input | 1 | End of process, active low, given with the final byte |
| hd_i | input | DW | Byte from the controller |
| hd_o | output | DW | Byte to the controller |
| hd_oe | output | 1 | Drive enable for hd_o |
| drq | output | 1 | DMA request |
| rdy | output | 1 | Wait-state control, high when ready |
| tx_data | output | DW | Outgoing byte to the SCSI engine |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Engine takes the outgoing byte |
| rx_data | input | DW | Incoming byte from the SCSI engine |
| rx_valid | input | 1 | Incoming byte offered |
| rx_ready | output | 1 | Port can take an incoming byte |
| eod_flag | output | 1 | End-of-transfer flag |
| err_flag | output | 1 | Misplaced-strobe flag |
| irq | output | 1 | Interrupt, OR of both flags |

## Verification
Every one of the 256 byte values is pushed through each direction, using arithmetic sequences that tell a dropped, stale or swapped byte apart from the correct one. The engine takes each outgoing byte after a delay that cycles through 0, 1 and 2 clocks. The pacing style is toggled partway through the outgoing sweep and on alternate bytes of the incoming sweep. This separates request-only pacing from wait-state pacing, and tells an early drain from a held byte. Separate sequences place the end-of-process strobe on a write and on a read, to show where the end flag appears. Others give strobes with the mode off, into a full or empty register and in the wrong direction, to tell ignored strobes apart from error strobes.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

    localparam int unsigned HSP_DW_DEFAULT = 8;

    typedef enum logic {
        DIR_TO_HOST = 1'b0,
        DIR_TO_SCSI = 1'b1
    } hsp_dir_e;

    typedef struct packed {
        logic wr_evt;     // first cycle of acknowledged write
        logic rd_evt;     // first cycle of acknowledged read
        logic rd_active;  // acknowledged read held low
        logic eop;        // end-of-process level, active high
    } hsp_strobe_t;

    function automatic logic fn_rise(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/hsp_strobe_dec.sv
module hsp_strobe_dec
    import hsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dack_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        eop_n,
    output hsp_strobe_t stb
);

    logic wr_now, rd_now;
    logic wr_q, rd_q;

    assign wr_now = ~dack_n & ~wr_n;
    assign rd_now = ~dack_n & ~rd_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_now;
            rd_q <= rd_now;
        end
    end

    always_comb begin
        stb.wr_evt    = fn_rise(wr_now, wr_q);
        stb.rd_evt    = fn_rise(rd_now, rd_q);
        stb.rd_active = rd_now;
        stb.eop       = ~eop_n;
    end

endmodule

// File: rtl/hsp_out_reg.sv
module hsp_out_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_on,
    input  logic          dir_ok,
    input  logic          wr_evt,
    input  logic [DW-1:0] din,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_data,
    output logic          full,
    output logic          accept,
    output logic          reject,
    output logic          drained
);

    logic [DW-1:0] data_q;
    logic          full_q;

    assign accept  = wr_evt & mode_on & dir_ok & ~full_q;
    assign reject  = wr_evt & mode_on & ~(dir_ok & ~full_q);
    assign drained = full_q & tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (accept) begin
                data_q <= din;
                full_q <= 1'b1;
            end else if (drained) begin
                full_q <= 1'b0;
            end
        end
    end

    assign tx_data = data_q;
    assign full    = full_q;

endmodule

// File: rtl/hsp_in_reg.sv
module hsp_in_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_on,
    input  logic          dir_ok,
    input  logic          halt,
    input  logic          rd_evt,
    input  logic          rd_active,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          taken,
    output logic          reject
);

    logic [DW-1:0] data_q;
    logic          full_q;
    logic          load;

    // no refill while the controller is still reading the held byte
    assign rx_ready = mode_on & dir_ok & ~full_q & ~halt & ~rd_active;
    assign load     = rx_valid & rx_ready;
    assign taken    = rd_evt & mode_on & dir_ok & full_q;
    assign reject   = rd_evt & mode_on & ~(dir_ok & full_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (load) begin
                data_q <= rx_data;
                full_q <= 1'b1;
            end else if (taken) begin
                full_q <= 1'b0;
            end
        end
    end

    assign dout = data_q;
    assign full = full_q;

endmodule

// File: rtl/hsp_term.sv
module hsp_term (
    input  logic clk,
    input  logic rst,
    input  logic mode_on,
    input  logic blk_on,
    input  logic dir_out,
    input  logic dack_n,
    input  logic out_full,
    input  logic in_full,
    input  logic wr_accept,
    input  logic rd_taken,
    input  logic out_drained,
    input  logic eop,
    input  logic bad_strobe,
    output logic halt,
    output logic drq,
    output logic rdy,
    output logic eod_flag,
    output logic err_flag,
    output logic irq
);

    logic pend_q, end_q, err_q, drq_q;
    logic can_move;

    assign halt     = pend_q | end_q;
    assign can_move = dir_out ? ~out_full : in_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            end_q  <= 1'b0;
            err_q  <= 1'b0;
            drq_q  <= 1'b0;
        end else begin
            drq_q <= mode_on & ~halt & can_move & dack_n;
            if (!mode_on) begin
                pend_q <= 1'b0;
                end_q  <= 1'b0;
                err_q  <= 1'b0;
            end else begin
                if (wr_accept && eop)
                    pend_q <= 1'b1;
                else if (out_drained)
                    pend_q <= 1'b0;
                if ((pend_q && out_drained) || (rd_taken && eop))
                    end_q <= 1'b1;
                if (bad_strobe)
                    err_q <= 1'b1;
            end
        end
    end

    assign drq      = drq_q;
    assign rdy      = ~(mode_on & blk_on) | (can_move & ~halt);
    assign eod_flag = end_q;
    assign err_flag = err_q;
    assign irq      = end_q | err_q;

endmodule

// File: rtl/hsp_dma_port.sv
module hsp_dma_port
    import hsp_pkg::*;
#(
    parameter int unsigned DW = HSP_DW_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dma_en,
    input  logic          blk_en,
    input  logic          dir_out,
    input  logic          dack_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          eop_n,
    input  logic [DW-1:0] hd_i,
    output logic [DW-1:0] hd_o,
    output logic          hd_oe,
    output logic          drq,
    output logic          rdy,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    output logic          eod_flag,
    output logic          err_flag,
    output logic          irq
);

    hsp_strobe_t stb;
    hsp_dir_e    dir;
    logic        to_scsi, to_host;
    logic        out_full, out_acc, out_rej, out_drn;
    logic        in_full, in_taken, in_rej;
    logic        halt;

    assign dir     = hsp_dir_e'(dir_out);
    assign to_scsi = (dir == DIR_TO_SCSI);
    assign to_host = (dir == DIR_TO_HOST);

    hsp_strobe_dec u_dec (
        .clk    (clk),
        .rst    (rst),
        .dack_n (dack_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .eop_n  (eop_n),
        .stb    (stb)
    );

    hsp_out_reg #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .mode_on  (dma_en),
        .dir_ok   (to_scsi),
        .wr_evt   (stb.wr_evt),
        .din      (hd_i),
        .tx_ready (tx_ready),
        .tx_data  (tx_data),
        .full     (out_full),
        .accept   (out_acc),
        .reject   (out_rej),
        .drained  (out_drn)
    );

    hsp_in_reg #(.DW(DW)) u_in (
        .clk       (clk),
        .rst       (rst),
        .mode_on   (dma_en),
        .dir_ok    (to_host),
        .halt      (halt),
        .rd_evt    (stb.rd_evt),
        .rd_active (stb.rd_active),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .dout      (hd_o),
        .full      (in_full),
        .taken     (in_taken),
        .reject    (in_rej)
    );

    hsp_term u_term (
        .clk         (clk),
        .rst         (rst),
        .mode_on     (dma_en),
        .blk_on      (blk_en),
        .dir_out     (to_scsi),
        .dack_n      (dack_n),
        .out_full    (out_full),
        .in_full     (in_full),
        .wr_accept   (out_acc),
        .rd_taken    (in_taken),
        .out_drained (out_drn),
        .eop         (stb.eop),
        .bad_strobe  (out_rej | in_rej),
        .halt        (halt),
        .drq         (drq),
        .rdy         (rdy),
        .eod_flag    (eod_flag),
        .err_flag    (err_flag),
        .irq         (irq)
    );

    assign tx_valid = out_full;
    assign hd_oe    = stb.rd_active & dma_en;

endmodule

// File: rtl/hsp_dma_port_chk.sv
module hsp_dma_port_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          dma_en,
    input logic          blk_en,
    input logic          dir_out,
    input logic          dack_n,
    input logic          rd_n,
    input logic [DW-1:0] tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          rx_ready,
    input logic          drq,
    input logic          rdy,
    input logic          hd_oe,
    input logic          eod_flag,
    input logic          err_flag
);

    p_drq_mode_r2: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !drq);

    p_drq_dack_r3: assert property (@(posedge clk) disable iff (rst)
        !dack_n |=> !drq);

    p_tx_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    p_oe_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        hd_oe |-> (!dack_n && !rd_n));

    p_rdy_full_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_en && blk_en && dir_out && tx_valid) |-> !rdy);

    p_end_halts_r7: assert property (@(posedge clk) disable iff (rst)
        eod_flag |-> (!drq && !rx_ready));

    p_flags_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> (!eod_flag && !err_flag));

    p_mode_off_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!dma_en && !tx_valid) |=> !tx_valid);

endmodule

bind hsp_dma_port hsp_dma_port_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dma_en   (dma_en),
    .blk_en   (blk_en),
    .dir_out  (dir_out),
    .dack_n   (dack_n),
    .rd_n     (rd_n),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_ready (rx_ready),
    .drq      (drq),
    .rdy      (rdy),
    .hd_oe    (hd_oe),
    .eod_flag (eod_flag),
    .err_flag (err_flag)
);

// File: tb/hsp_dma_port_bench.sv
`timescale 1ns/1ps
module hsp_dma_port_bench;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dma_en = 1'b0, blk_en = 1'b0, dir_out = 1'b1;
    logic          dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eop_n = 1'b1;
    logic [DW-1:0] hd_i = '0;
    logic [DW-1:0] hd_o;
    logic          hd_oe, drq, rdy;
    logic [DW-1:0] tx_data;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_valid = 1'b0;
    logic          rx_ready, eod_flag, err_flag, irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hsp_dma_port #(.DW(DW)) u_hsp_dma_port (
        .clk(clk), .rst(rst), .dma_en(dma_en), .blk_en(blk_en), .dir_out(dir_out),
        .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n), .eop_n(eop_n),
        .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe), .drq(drq), .rdy(rdy),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .eod_flag(eod_flag), .err_flag(err_flag), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_drq();
        for (int k = 0; k < 8 && drq !== 1'b1; k++) @(negedge clk);
    endtask

    task automatic release_strobes();
        dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eop_n = 1'b1;
    endtask

    task automatic drain_tx();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic mode_off_pulse();
        @(negedge clk); dma_en = 1'b0;
        @(negedge clk); dma_en = 1'b1;
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 drq", drq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 irq", irq, 0);
        chk("R1 eod", eod_flag, 0);
        chk("R1 err", err_flag, 0);
        chk("R1 rdy", rdy, 1);

        // R9 strobes with mode off
        dir_out = 1'b1; hd_i = 8'h5A; dack_n = 1'b0; wr_n = 1'b0; eop_n = 1'b0;
        @(negedge clk); release_strobes();
        @(negedge clk);
        chk("R9 write ignored tx_valid", tx_valid, 0);
        chk("R9 no flag", irq, 0);
        dir_out = 1'b0; rx_valid = 1'b1; rx_data = 8'h33; #1;
        chk("R9 rx_ready off", rx_ready, 0);
        dack_n = 1'b0; rd_n = 1'b0; #1;
        chk("R9 hd_oe off", hd_oe, 0);
        @(negedge clk); release_strobes(); rx_valid = 1'b0;
        @(negedge clk);
        chk("R9 read no flag", irq, 0);

        // outgoing sweep: R2 R3 R4 R6
        dma_en = 1'b1; dir_out = 1'b1;
        for (int i = 0; i < 256; i++) begin
            v = 8'((i * 29 + 7) & 255);
            @(negedge clk); blk_en = (i >= 128);
            wait_drq();
            chk("R2 drq out empty", drq, 1);
            chk("R6 rdy empty", rdy, 1);
            hd_i = v; dack_n = 1'b0; wr_n = 1'b0;
            @(negedge clk);
            chk("R3 drq after dack", drq, 0);
            chk("R4 tx_valid", tx_valid, 1);
            chk("R4 tx_data", tx_data, v);
            chk("R6 rdy full", rdy, blk_en ? 0 : 1);
            release_strobes();
            for (int d = 0; d < i % 3; d++) @(negedge clk);
            chk("R4 held data", tx_data, v);
            chk("R2 drq while full", drq, 0);
            drain_tx();
            chk("R4 drained", tx_valid, 0);
        end

        // incoming sweep: R2 R3 R5 R6
        @(negedge clk); dir_out = 1'b0;
        for (int i = 0; i < 256; i++) begin
            v = 8'((i * 53 + 11) & 255);
            @(negedge clk); blk_en = i[0];
            rx_data = v; rx_valid = 1'b1; #1;
            chk("R5 rx_ready empty", rx_ready, 1);
            chk("R6 rdy in empty", rdy, blk_en ? 0 : 1);
            @(negedge clk); rx_valid = 1'b0; #1;
            chk("R5 rx_ready full", rx_ready, 0);
            wait_drq();
            chk("R2 drq in full", drq, 1);
            chk("R6 rdy in full", rdy, 1);
            dack_n = 1'b0; rd_n = 1'b0; #1;
            chk("R5 hd_oe", hd_oe, 1);
            chk("R5 hd_o", hd_o, v);
            @(negedge clk);
            chk("R3 drq after dack rd", drq, 0);
            chk("R5 hd_o held", hd_o, v);
            release_strobes(); #1;
            chk("R5 hd_oe off", hd_oe, 0);
        end

        // R7 end on write, then R8
        @(negedge clk); dir_out = 1'b1; blk_en = 1'b0;
        wait_drq();
        hd_i = 8'hC3; dack_n = 1'b0; wr_n = 1'b0; eop_n = 1'b0;
        @(negedge clk); release_strobes();
        @(negedge clk);
        chk("R7 no end before drain", eod_flag, 0);
        drain_tx();
        chk("R7 eod after drain", eod_flag, 1);
        chk("R7 irq", irq, 1);
        repeat (4) @(negedge clk);
        chk("R7 no drq after end", drq, 0);
        @(negedge clk); dma_en = 1'b0;
        @(negedge clk);
        chk("R8 eod cleared", eod_flag, 0);
        chk("R8 irq cleared", irq, 0);
        chk("R8 drq off", drq, 0);

        // R7 end on read
        dma_en = 1'b1; dir_out = 1'b0;
        rx_data = 8'h96; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        wait_drq();
        dack_n = 1'b0; rd_n = 1'b0; eop_n = 1'b0;
        @(negedge clk); release_strobes();
        chk("R7 eod on read", eod_flag, 1);
        rx_valid = 1'b1; #1;
        chk("R7 rx_ready halted", rx_ready, 0);
        @(negedge clk); rx_valid = 1'b0;
        chk("R7 drq halted", drq, 0);
        mode_off_pulse();
        chk("R8 eod cleared read", eod_flag, 0);

        // R10 write into full register
        dir_out = 1'b1;
        @(negedge clk); hd_i = 8'h11; dack_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); release_strobes();
        @(negedge clk); hd_i = 8'h22; dack_n = 1'b0; wr_n = 1'b0;
        @(negedge clk); release_strobes();
        chk("R10 err full write", err_flag, 1);
        chk("R10 irq", irq, 1);
        chk("R10 byte kept", tx_data, 8'h11);
        drain_tx();
        mode_off_pulse();
        chk("R8 err cleared", err_flag, 0);

        // R10 read while empty
        dir_out = 1'b0;
        @(negedge clk); dack_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); release_strobes();
        chk("R10 err empty read", err_flag, 1);
        mode_off_pulse();

        // R10 wrong direction read
        dir_out = 1'b1;
        @(negedge clk); dack_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); release_strobes();
        chk("R10 err wrong dir", err_flag, 1);
        chk("R10 nothing loaded", tx_valid, 0);
        mode_off_pulse();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule